// File: doc/BRIEF.md
# Segment Address Translator

This block sits between a processor core and the system bus. Each core access carries a virtual address, the current task number, the access kind (read, write or instruction fetch) and the privilege mode. The block looks the access up in a small table of programmable segment descriptors and returns the physical bus address and that segment's memory attributes. When the access hits no usable segment, or when the segment forbids it, the access is aborted toward the core.

The lookup key joins the task number to the virtual address. As a result, two tasks can use the same virtual range and reach different physical memory. A descriptor can also be marked as shared by all tasks. A fixed window at the top of the virtual space is never translated, so debug logic and on-chip registers stay reachable at their own addresses. The first denied access is recorded in status registers until software clears it. Later denials before that clear only set a sticky overflow flag.

Software programs descriptors and reads status through a simple register port. The same block is used once for data, with 20 descriptors, and once for instruction fetch, with 12 descriptors.

Top module: `seg_xlate_top`

## Requirements
- R1: A valid descriptor matches only when its task field equals `req_tid`, unless its all-tasks flag (control bit 1) is set. In that case the task number is ignored.
- R2: When several valid descriptors match one access, the descriptor with the lowest index supplies the result.
- R3: On a hit, `rsp_pa` takes the physical base for the bits at and above the segment size exponent (control bits 12:8). Below that exponent it takes the request's own virtual address bits.
- R4: On a hit, `rsp_attr` returns the hit descriptor's six attribute bits (control bits 18:13): bit 0 cacheable, bit 1 prefetch, bit 2 shared, bit 3 write-back, bits 5:4 burst size.
- R5: A hit whose permission bit is clear aborts the access. Control bits 4:2 are supervisor read, write and fetch. Bits 7:5 are the same three for user mode. A write uses the write bit, a fetch the fetch bit, anything else the read bit. An aborted response has `rsp_pa` and `rsp_attr` equal to zero.
- R6: An access outside the bypass window that matches no descriptor aborts with the miss flag set.
- R7: An address whose top four bits are all ones is returned unchanged in `rsp_pa`, with zero attributes and no abort, whatever the table holds.
- R8: `rsp_valid` is high exactly one cycle after `req_valid`, and only then.
- R9: The first aborted access is recorded and can be read at register address 0x7C. Bit 0 is fault valid, bit 2 is miss, bit 3 write, bit 4 fetch, bit 5 user. The faulting virtual address reads at 0x7D and the task number at 0x7E. The record is kept until it is cleared.
- R10: An abort while a record is held sets the sticky overflow bit (bit 1 of 0x7C) and leaves the record unchanged. Writing 1 to bit 0 of 0x7C clears both the record and the overflow bit. If that clear lands in the same cycle as a new abort, the new abort is recorded and overflow reads 0.
- R11: Descriptor i occupies register addresses 4i (control: bits 18:0 as above, task at bits 31:24), 4i+1 (virtual base) and 4i+2 (physical base). Read data appears on `reg_rdata` one cycle after `reg_addr` is presented. After reset every register reads zero.
- R12: A descriptor whose valid bit (control bit 0) is clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_va | input | 32 | Virtual address |
| req_tid | input | 8 | Current task number |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user mode |
| rsp_valid | output | 1 | Result present, one cycle after request |
| rsp_abort | output | 1 | Access denied (exception to core) |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 6 | Segment attributes of the hit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle latency |

## Verification
Two functions can meet in a single cycle: software clearing the fault record, and a new denied access that wants to fill that record. The bench first leaves an old fault in place. It then drives the clear write and a missing access on the same clock edge. It judges the outcome by reading the status words back. The new address and miss flag must be present, with the overflow bit low. Random streams also interleave clears with aborts, and the status is compared with a bench model after each clear point.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // memory attributes carried by a segment, LSB = cacheable
  typedef struct packed {
    logic [1:0] burst;
    logic       wback;
    logic       shared;
    logic       prefetch;
    logic       cache;
  } seg_attr_t;

  // descriptor control word, bit 0 = valid; packs into word bits 18:0
  typedef struct packed {
    seg_attr_t  attr;
    logic [4:0] size_exp;
    logic [5:0] perm;     // {ux,uw,ur,sx,sw,sr}
    logic       all_tasks;
    logic       valid;
  } seg_ctrl_t;

  localparam int CTRL_W = $bits(seg_ctrl_t);
  localparam int TID_LSB = 24;

endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 20,
  parameter int AW      = 32,
  parameter int TID_W   = 8,
  parameter int SEG_AW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEG_AW-1:0] wr_seg,
  input  logic [1:0]        wr_word,
  input  logic [31:0]       wr_data,
  output seg_ctrl_t         ctrl  [NUM_SEG],
  output logic [TID_W-1:0]  tid   [NUM_SEG],
  output logic [AW-1:0]     vbase [NUM_SEG],
  output logic [AW-1:0]     pbase [NUM_SEG]
);

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[TID_LSB-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        ctrl[i]  <= '0;
        tid[i]   <= '0;
        vbase[i] <= '0;
        pbase[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (wr_seg == SEG_AW'(i)) begin
          case (wr_word)
            2'd0: begin
              ctrl[i] <= seg_ctrl_t'(wr_data[CTRL_W-1:0]);
              tid[i]  <= wr_data[TID_LSB +: TID_W];
            end
            2'd1: vbase[i] <= wr_data[AW-1:0];
            2'd2: pbase[i] <= wr_data[AW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/seg_xlate_lookup.sv
module seg_xlate_lookup
  import seg_xlate_pkg::*;
#(
  parameter int             NUM_SEG = 20,
  parameter int             AW      = 32,
  parameter int             TID_W   = 8,
  parameter int             BYP_W   = 4,
  parameter logic [BYP_W-1:0] BYP_TAG = '1
) (
  input  seg_ctrl_t         ctrl  [NUM_SEG],
  input  logic [TID_W-1:0]  tid   [NUM_SEG],
  input  logic [AW-1:0]     vbase [NUM_SEG],
  input  logic [AW-1:0]     pbase [NUM_SEG],
  input  logic [AW-1:0]     va,
  input  logic [TID_W-1:0]  cur_tid,
  input  logic              is_write,
  input  logic              is_exec,
  input  logic              is_user,
  output logic              bypass,
  output logic              hit,
  output logic              perm_ok,
  output logic [AW-1:0]     pa,
  output seg_attr_t         attr
);

  logic [NUM_SEG-1:0] match;
  logic [AW-1:0]      seg_pa [NUM_SEG];
  logic [5:0]         sel_perm;
  logic [2:0]         mode_perm;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [AW-1:0] hi_mask;
    assign hi_mask   = {AW{1'b1}} << ctrl[g].size_exp;
    assign match[g]  = ctrl[g].valid
                     && (ctrl[g].all_tasks || (tid[g] == cur_tid))
                     && (((va ^ vbase[g]) & hi_mask) == '0);
    assign seg_pa[g] = (pbase[g] & hi_mask) | (va & ~hi_mask);
  end

  // descending scan: the lowest matching index is assigned last
  always_comb begin
    hit      = 1'b0;
    pa       = '0;
    attr     = '0;
    sel_perm = '0;
    for (int i = NUM_SEG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        pa       = seg_pa[i];
        attr     = ctrl[i].attr;
        sel_perm = ctrl[i].perm;
      end
    end
  end

  assign mode_perm = is_user ? sel_perm[5:3] : sel_perm[2:0];
  assign perm_ok   = is_write ? mode_perm[1] : (is_exec ? mode_perm[2] : mode_perm[0]);
  assign bypass    = (va[AW-1 -: BYP_W] == BYP_TAG);

endmodule

// File: rtl/seg_xlate_fault.sv
module seg_xlate_fault #(
  parameter int AW    = 32,
  parameter int TID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             fault_ev,
  input  logic             ev_miss,
  input  logic             ev_write,
  input  logic             ev_exec,
  input  logic             ev_user,
  input  logic [AW-1:0]    ev_va,
  input  logic [TID_W-1:0] ev_tid,
  output logic             held,
  output logic             ovf,
  output logic [3:0]       flags,   // {user, exec, write, miss}
  output logic [AW-1:0]    f_va,
  output logic [TID_W-1:0] f_tid
);

  logic keep;
  assign keep = held && !clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= 1'b0;
      ovf   <= 1'b0;
      flags <= '0;
      f_va  <= '0;
      f_tid <= '0;
    end else begin
      if (clear) begin
        held <= 1'b0;
        ovf  <= 1'b0;
      end
      if (fault_ev) begin
        if (!keep) begin
          held  <= 1'b1;
          flags <= {ev_user, ev_exec, ev_write, ev_miss};
          f_va  <= ev_va;
          f_tid <= ev_tid;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end

  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (rst)
    keep |=> (held && $stable(f_va) && $stable(f_tid) && $stable(flags))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clear) |=> ovf); // R10
  AST_OVF_NEEDS_RECORD: assert property (@(posedge clk) disable iff (rst)
    ovf |-> held); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clear && !fault_ev) |=> (!held && !ovf)); // R10

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int               NUM_SEG = 20,
  parameter int               AW      = 32,
  parameter int               TID_W   = 8,
  parameter int               BYP_W   = 4,
  parameter logic [BYP_W-1:0] BYP_TAG = '1,
  localparam int              SEG_AW  = $clog2(NUM_SEG + 1),
  localparam int              ADDR_W  = SEG_AW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_va,
  input  logic [TID_W-1:0]  req_tid,
  input  logic              req_write,
  input  logic              req_exec,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic              rsp_abort,
  output logic [AW-1:0]     rsp_pa,
  output logic [5:0]        rsp_attr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam logic [SEG_AW-1:0] STAT_SEG = '1;

  seg_ctrl_t        d_ctrl  [NUM_SEG];
  logic [TID_W-1:0] d_tid   [NUM_SEG];
  logic [AW-1:0]    d_vbase [NUM_SEG];
  logic [AW-1:0]    d_pbase [NUM_SEG];

  logic [SEG_AW-1:0] a_seg;
  logic [1:0]        a_word;
  logic              tbl_wr, stat_clr;
  assign a_seg    = reg_addr[ADDR_W-1:2];
  assign a_word   = reg_addr[1:0];
  assign tbl_wr   = reg_wr && (a_seg < SEG_AW'(NUM_SEG));
  assign stat_clr = reg_wr && (a_seg == STAT_SEG) && (a_word == 2'd0) && reg_wdata[0];

  seg_xlate_table #(.NUM_SEG(NUM_SEG), .AW(AW), .TID_W(TID_W), .SEG_AW(SEG_AW)) u_table (
    .clk(clk), .rst(rst), .wr_en(tbl_wr), .wr_seg(a_seg), .wr_word(a_word),
    .wr_data(reg_wdata), .ctrl(d_ctrl), .tid(d_tid), .vbase(d_vbase), .pbase(d_pbase)
  );

  logic      lk_bypass, lk_hit, lk_ok;
  logic [AW-1:0] lk_pa;
  seg_attr_t lk_attr;

  seg_xlate_lookup #(.NUM_SEG(NUM_SEG), .AW(AW), .TID_W(TID_W), .BYP_W(BYP_W),
                     .BYP_TAG(BYP_TAG)) u_lookup (
    .ctrl(d_ctrl), .tid(d_tid), .vbase(d_vbase), .pbase(d_pbase),
    .va(req_va), .cur_tid(req_tid), .is_write(req_write), .is_exec(req_exec),
    .is_user(req_user), .bypass(lk_bypass), .hit(lk_hit), .perm_ok(lk_ok),
    .pa(lk_pa), .attr(lk_attr)
  );

  logic fault_ev;
  assign fault_ev = req_valid && !lk_bypass && !(lk_hit && lk_ok);

  logic             f_held, f_ovf;
  logic [3:0]       f_flags;
  logic [AW-1:0]    f_va;
  logic [TID_W-1:0] f_tid;

  seg_xlate_fault #(.AW(AW), .TID_W(TID_W)) u_fault (
    .clk(clk), .rst(rst), .clear(stat_clr), .fault_ev(fault_ev),
    .ev_miss(!lk_hit), .ev_write(req_write), .ev_exec(req_exec), .ev_user(req_user),
    .ev_va(req_va), .ev_tid(req_tid), .held(f_held), .ovf(f_ovf), .flags(f_flags),
    .f_va(f_va), .f_tid(f_tid)
  );

  // response stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_abort <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_abort <= fault_ev;
      if (req_valid && lk_bypass) begin
        rsp_pa   <= req_va;
        rsp_attr <= '0;
      end else if (req_valid && !fault_ev) begin
        rsp_pa   <= lk_pa;
        rsp_attr <= lk_attr;
      end else begin
        rsp_pa   <= '0;
        rsp_attr <= '0;
      end
    end
  end

  // register read path
  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (a_seg == STAT_SEG) begin
      case (a_word)
        2'd0: rd_next[5:0] = {f_flags, f_ovf, f_held};
        2'd1: rd_next[AW-1:0] = f_va;
        2'd2: rd_next[TID_W-1:0] = f_tid;
        default: ;
      endcase
    end else if (a_seg < SEG_AW'(NUM_SEG)) begin
      case (a_word)
        2'd0: begin
          rd_next[CTRL_W-1:0]       = d_ctrl[a_seg];
          rd_next[TID_LSB +: TID_W] = d_tid[a_seg];
        end
        2'd1: rd_next[AW-1:0] = d_vbase[a_seg];
        2'd2: rd_next[AW-1:0] = d_pbase[a_seg];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R8
  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R8
  AST_BYPASS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_va[AW-1 -: BYP_W] == BYP_TAG))
      |=> (rsp_pa == $past(req_va) && !rsp_abort && rsp_attr == '0)); // R7
  AST_ABORT_RECORDED: assert property (@(posedge clk) disable iff (rst)
    rsp_abort |-> f_held); // R9
  AST_ABORT_ZEROES: assert property (@(posedge clk) disable iff (rst)
    rsp_abort |-> (rsp_pa == '0 && rsp_attr == '0)); // R5

endmodule

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 20;
  localparam logic [6:0] ST0 = 7'h7C, ST1 = 7'h7D, ST2 = 7'h7E;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_exec = 0, req_user = 0;
  logic [31:0] req_va = 0;
  logic [7:0] req_tid = 0;
  logic rsp_valid, rsp_abort;
  logic [31:0] rsp_pa;
  logic [5:0] rsp_attr;
  logic reg_wr = 0;
  logic [6:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  seg_xlate_top i_seg_xlate_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_tid(req_tid),
    .req_write(req_write), .req_exec(req_exec), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_abort(rsp_abort), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of the table and fault record
  logic [18:0] m_ctrl [NSEG];
  logic [7:0]  m_tid  [NSEG];
  logic [31:0] m_vb   [NSEG];
  logic [31:0] m_pb   [NSEG];
  logic m_held = 0, m_ovf = 0;
  logic [3:0] m_flags = 0;
  logic [31:0] m_fva = 0;
  logic [7:0] m_ftid = 0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // returns {miss, abort, attr[5:0], pa[31:0]}
  function automatic logic [39:0] model(input logic [31:0] va, input logic [7:0] t,
                                        input logic w, input logic x, input logic u);
    logic [31:0] hm;
    logic [5:0] pm;
    logic ok;
    if (va[31:28] == 4'hF) return {2'b00, 6'd0, va};
    for (int i = 0; i < NSEG; i++) begin
      if (m_ctrl[i][0] && (m_ctrl[i][1] || m_tid[i] == t)) begin
        hm = 32'hFFFF_FFFF << m_ctrl[i][12:8];
        if (((va ^ m_vb[i]) & hm) == 0) begin
          pm = m_ctrl[i][7:2];
          if (u) ok = w ? pm[4] : (x ? pm[5] : pm[3]);
          else   ok = w ? pm[1] : (x ? pm[2] : pm[0]);
          if (!ok) return {2'b01, 38'd0};
          return {2'b00, m_ctrl[i][18:13], (m_pb[i] & hm) | (va & ~hm)};
        end
      end
    end
    return {2'b11, 38'd0};
  endfunction

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic prog(input int i, input logic [18:0] c, input logic [7:0] t,
                      input logic [31:0] vb, input logic [31:0] pb);
    wr_reg({i[4:0], 2'd0}, {t, 5'd0, c});
    wr_reg({i[4:0], 2'd1}, vb);
    wr_reg({i[4:0], 2'd2}, pb);
    m_ctrl[i] = c; m_tid[i] = t; m_vb[i] = vb; m_pb[i] = pb;
  endtask

  task automatic model_fault(input logic [39:0] e, input logic [31:0] va, input logic [7:0] t,
                             input logic w, input logic x, input logic u);
    if (e[38]) begin
      if (!m_held) begin
        m_held = 1; m_flags = {u, x, w, e[39]}; m_fva = va; m_ftid = t;
      end else m_ovf = 1;
    end
  endtask

  task automatic access(input string r, input logic [31:0] va, input logic [7:0] t,
                        input logic w, input logic x, input logic u);
    logic [39:0] e;
    e = model(va, t, w, x, u);
    @(negedge clk);
    req_valid = 1; req_va = va; req_tid = t; req_write = w; req_exec = x; req_user = u;
    model_fault(e, va, t, w, x, u);
    @(negedge clk);
    req_valid = 0;
    chk({r, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({r, " abort"}, 64'(rsp_abort), 64'(e[38]));
    chk({r, " pa"}, 64'(rsp_pa), 64'(e[31:0]));
    chk({r, " attr"}, 64'(rsp_attr), 64'(e[37:32]));
  endtask

  task automatic check_status(input string r);
    logic [31:0] d;
    rd_reg(ST0, d);
    chk({r, " status"}, 64'(d), 64'({26'd0, m_flags, m_ovf, m_held}));
    if (m_held) begin
      rd_reg(ST1, d); chk({r, " fault va"}, 64'(d), 64'(m_fva));
      rd_reg(ST2, d); chk({r, " fault tid"}, 64'(d), 64'(m_ftid));
    end
  endtask

  task automatic clear_status();
    wr_reg(ST0, 32'd1);
    m_held = 0; m_ovf = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NSEG; i++) begin
      m_ctrl[i] = 0; m_tid[i] = 0; m_vb[i] = 0; m_pb[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R11: reset state
    chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
    rd_reg(7'h00, d); chk("R11 reset desc0 ctrl", 64'(d), 64'd0);
    check_status("R9 reset");

    // R6 / R12: empty table misses
    access("R6 miss empty", 32'h0000_1000, 8'd1, 1'b0, 1'b0, 1'b0);
    check_status("R9 first fault");
    access("R6 second miss", 32'h0000_2000, 8'd2, 1'b1, 1'b0, 1'b1);
    check_status("R10 overflow");
    clear_status();
    check_status("R10 cleared");

    // seg0: tid 3, size 2^12, sup rwx, user read; attr 0x2D
    prog(0, {6'h2D, 5'd12, 6'b001_111, 1'b0, 1'b1}, 8'd3, 32'h0001_0000, 32'h8000_0000);
    rd_reg(7'h00, d);
    chk("R11 desc0 ctrl readback", 64'(d), 64'({8'd3, 5'd0, 6'h2D, 5'd12, 6'b001_111, 2'b01}));
    rd_reg(7'h02, d); chk("R11 desc0 pbase readback", 64'(d), 64'h8000_0000);
    // seg1: all tasks, size 2^16, full permission, attr 0x13
    prog(1, {6'h13, 5'd16, 6'b111_111, 1'b1, 1'b1}, 8'd9, 32'h0001_0000, 32'h9000_0000);

    access("R3 R4 hit seg0", 32'h0001_0ABC, 8'd3, 1'b0, 1'b0, 1'b0);
    chk("R3 pa value", 64'(rsp_pa), 64'h8000_0ABC);
    access("R2 seg0 wins", 32'h0001_0004, 8'd3, 1'b1, 1'b0, 1'b0);
    access("R1 other task falls to shared seg1", 32'h0001_0ABC, 8'd2, 1'b0, 1'b0, 1'b0);
    chk("R1 pa from seg1", 64'(rsp_pa), 64'h9000_0ABC);
    access("R5 user read allowed", 32'h0001_0010, 8'd3, 1'b0, 1'b0, 1'b1);
    access("R5 user write denied", 32'h0001_0010, 8'd3, 1'b1, 1'b0, 1'b1);
    check_status("R5 R9 permission fault recorded");
    clear_status();
    access("R5 user fetch denied", 32'h0001_0020, 8'd3, 1'b0, 1'b1, 1'b1);
    clear_status();

    // R12: invalidate seg0
    prog(0, {6'h2D, 5'd12, 6'b001_111, 1'b0, 1'b0}, 8'd3, 32'h0001_0000, 32'h8000_0000);
    access("R12 invalid seg skipped", 32'h0001_0ABC, 8'd3, 1'b0, 1'b0, 1'b0);
    chk("R12 pa from seg1", 64'(rsp_pa), 64'h9000_0ABC);

    // R7: bypass window
    access("R7 bypass", 32'hF000_1234, 8'd7, 1'b1, 1'b1, 1'b1);
    chk("R7 pa unchanged", 64'(rsp_pa), 64'hF000_1234);
    check_status("R7 no record");

    // R10: clear and new fault in the same cycle
    access("R10 prior fault", 32'h0000_4000, 8'd4, 1'b0, 1'b0, 1'b0);
    access("R10 overflow", 32'h0000_4100, 8'd4, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    reg_wr = 1; reg_addr = ST0; reg_wdata = 32'd1;
    req_valid = 1; req_va = 32'h0000_5000; req_tid = 8'd6;
    req_write = 1; req_exec = 0; req_user = 0;
    @(negedge clk);
    reg_wr = 0; req_valid = 0;
    chk("R10 same-cycle abort", 64'(rsp_abort), 64'd1);
    m_held = 1; m_ovf = 0; m_flags = 4'b0011; m_fva = 32'h0000_5000; m_ftid = 8'd6;
    check_status("R10 same-cycle clear keeps new fault");
    clear_status();

    // random table and accesses
    for (int i = 0; i < NSEG; i++) begin
      logic [18:0] c;
      c = {6'($urandom), 5'(12 + $urandom_range(0, 8)), 6'($urandom),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 7) != 0)};
      prog(i, c, 8'($urandom_range(0, 3)), $urandom & 32'h001F_FFFF, $urandom & 32'hEFFF_FFFF);
    end
    for (int n = 0; n < 400; n++) begin
      int j;
      logic [31:0] va;
      int k;
      j = $urandom_range(0, NSEG - 1);
      k = $urandom_range(0, 9);
      if (k == 0)      va = 32'hF000_0000 | ($urandom & 32'h0FFF_FFFF);
      else if (k == 1) va = $urandom & 32'h001F_FFFF;
      else             va = m_vb[j] ^ ($urandom & ((32'd1 << m_ctrl[j][12:8]) - 1));
      access("R1 R2 R3 R4 R5 random", va, 8'($urandom_range(0, 3)),
             1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom));
      if (n % 40 == 39) begin
        check_status("R9 R10 random");
        clear_status();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule